// File: doc/BRIEF.md
# Framebuffer Control and Status Register Bank

This block holds the control and status bytes of a simple framebuffer controller, and the frame interrupt that they govern. It decodes the upper half (offsets 0x10 to 0x1F) of a 32-byte register window. The bus presents a word address and one enable per byte lane, so a single access can cover one to four bytes. The lower half of the window belongs to a neighbouring palette block. This bank reads as zero there and ignores writes.

The control byte carries an interrupt-enable flag. A one-cycle frame-end pulse from the scanout logic sets a sticky pending flag when that enable is on. The pending flag drives a level interrupt output. The status byte returns the pending flag together with hard-wired identity bits that describe the monitor type and mark a colour board. Writing the status byte with any data clears the pending flag. The remaining offsets hold cursor and video-control settings as plain bytes.

Top module: `fbc_ctrl_regs`

## Requirements
- R1: Reset is synchronous and active high. It clears the interrupt output, the pending flag, the control byte and every storage byte, and it clears the read data register to zero. After reset, a status read returns 0x61.
- R2: The control byte sits at offset 0x10, and a read returns all eight bits exactly as they were written.
- R3: On a clock edge where `frame_end` is high and bit 7 of the control byte is 1, the interrupt output goes high after that edge. When bit 7 is 0, `frame_end` has no effect.
- R4: A read of the status byte at offset 0x11 returns the pending flag in bit 7, ORed with the constant 0x61. Reading the status byte does not change the pending flag or the interrupt output.
- R5: A write to offset 0x11 clears the pending flag and drops the interrupt output after that edge, whatever the data written. The data itself is never stored.
- R6: When a frame-end event with the enable set meets a status write in the same cycle, the pending flag ends up set.
- R7: The pending flag is sticky. It stays set across later cycles, further frame ends and a cleared enable, until a status write clears it.
- R8: Offsets 0x12 to 0x1F, which hold cursor start, cursor end, video control and spare bytes, each read back the last byte written to them.
- R9: Data lane i (bits 8i+7..8i) maps to byte offset 4*`bus_waddr`+i. Only lanes whose `bus_be` bit is 1 are written. Lanes whose bit is 0 read as zero.
- R10: Offsets 0x00 to 0x0F read as zero. A write there changes no register of this bank.
- R11: `bus_rdata` is registered. It takes the read value on the edge where `bus_rd` is high, and it holds that value until the next read, even across writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_waddr | input | 3 | Word address within the 32-byte window |
| bus_be | input | 4 | Byte lane enables |
| bus_wdata | input | 32 | Write data, lane i = bits 8i+7..8i |
| bus_rdata | output | 32 | Registered read data |
| frame_end | input | 1 | One-cycle pulse at the end of each frame |
| irq | output | 1 | Level frame interrupt, high while pending |

## Verification
The bench builds the block with its defaults: four byte lanes, a 32-byte window, and a 16-byte bank based at 0x10. With these values, a single word access can span the control byte, the status byte and two storage bytes at once. This is how lane masking and the ignored status data are checked together. The defaults also leave word addresses 0 to 3 outside the bank, which brings the zero-read and no-effect behaviour of the palette half within reach.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
  // bank-relative index of each decoded byte (behaviour depends on these)
  localparam int unsigned CTRL_IDX  = 0;
  localparam int unsigned STAT_IDX  = 1;
  // bit positions inside control and status bytes
  localparam int unsigned IEN_BIT   = 7;
  localparam int unsigned PEND_BIT  = 7;
  // fixed identity: monitor type code plus colour-board flag
  localparam logic [7:0]  IDENT_BITS = 8'h61;
endpackage

// File: rtl/fbc_lane_decode.sv
module fbc_lane_decode #(
  parameter int unsigned LANES      = 4,
  parameter int unsigned WORD_W     = 3,
  parameter int unsigned BANK_BASE  = 16,
  parameter int unsigned BANK_BYTES = 16,
  parameter int unsigned IDX_W      = 4
) (
  input  logic [WORD_W-1:0]           waddr,
  output logic [LANES-1:0]            hit,
  output logic [LANES-1:0][IDX_W-1:0] idx
);
  localparam int unsigned LB    = $clog2(LANES);
  localparam int unsigned OFS_W = WORD_W + LB + 1;
  localparam logic [OFS_W-1:0] LO = OFS_W'(BANK_BASE);
  localparam logic [OFS_W-1:0] HI = OFS_W'(BANK_BASE + BANK_BYTES);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [LB-1:0] LANE_ID = LB'(i);
    logic [OFS_W-1:0] ofs;
    logic [OFS_W-1:0] rel;
    assign ofs    = {1'b0, waddr, LANE_ID};
    assign rel    = ofs - LO;
    assign hit[i] = (ofs >= LO) && (ofs < HI);
    assign idx[i] = rel[IDX_W-1:0];
  end
endmodule

// File: rtl/fbc_byte_store.sv
module fbc_byte_store
  import fbc_pkg::*;
#(
  parameter int unsigned LANES      = 4,
  parameter int unsigned BANK_BYTES = 16,
  parameter int unsigned IDX_W      = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr,
  input  logic [LANES-1:0]               be,
  input  logic [8*LANES-1:0]             wdata,
  input  logic [LANES-1:0]               hit,
  input  logic [LANES-1:0][IDX_W-1:0]    idx,
  output logic [BANK_BYTES-1:0][7:0]     q,
  output logic                           stat_wr
);
  for (genvar b = 0; b < BANK_BYTES; b++) begin : g_byte
    if (b == STAT_IDX) begin : g_stat
      // status byte is computed on read, never stored
      assign q[b] = '0;
    end else begin : g_reg
      logic [7:0] byte_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          byte_q <= '0;
        end else begin
          for (int l = 0; l < LANES; l++) begin
            if (wr && be[l] && hit[l] && (idx[l] == IDX_W'(b)))
              byte_q <= wdata[8*l +: 8];
          end
        end
      end
      assign q[b] = byte_q;
    end
  end

  always_comb begin
    stat_wr = 1'b0;
    for (int l = 0; l < LANES; l++)
      if (wr && be[l] && hit[l] && (idx[l] == IDX_W'(STAT_IDX)))
        stat_wr = 1'b1;
  end
endmodule

// File: rtl/fbc_irq.sv
module fbc_irq (
  input  logic clk,
  input  logic rst,
  input  logic frame_end,
  input  logic ien,
  input  logic clr,
  output logic irq
);
  // pending flag doubles as the registered interrupt level
  always_ff @(posedge clk) begin
    if (rst)                    irq <= 1'b0;
    else if (frame_end && ien)  irq <= 1'b1;
    else if (clr)               irq <= 1'b0;
  end

  // R1
  rst_clears_irq_chk: assert property (@(posedge clk) rst |=> !irq);
  // R3
  frame_sets_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_end && ien) |=> irq);
  // R3
  disabled_no_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!ien && !irq) |=> !irq);
  // R5
  status_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !(frame_end && ien)) |=> !irq);
  // R6
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && frame_end && ien) |=> irq);
  // R7
  sticky_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr) |=> irq);
endmodule

// File: rtl/fbc_ctrl_regs.sv
module fbc_ctrl_regs
  import fbc_pkg::*;
#(
  parameter int unsigned LANES      = 4,
  parameter int unsigned WIN_BYTES  = 32,
  parameter int unsigned BANK_BASE  = 16,
  parameter int unsigned BANK_BYTES = 16,
  localparam int unsigned DATA_W    = 8 * LANES,
  localparam int unsigned WORD_W    = $clog2(WIN_BYTES) - $clog2(LANES),
  localparam int unsigned IDX_W     = $clog2(BANK_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [WORD_W-1:0] bus_waddr,
  input  logic [LANES-1:0]  bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              frame_end,
  output logic              irq
);
  logic [LANES-1:0]            hit;
  logic [LANES-1:0][IDX_W-1:0] idx;
  logic [BANK_BYTES-1:0][7:0]  bytes_q;
  logic                        stat_wr;
  logic [DATA_W-1:0]           rd_next;
  logic [7:0]                  stat_val;

  fbc_lane_decode #(
    .LANES(LANES), .WORD_W(WORD_W), .BANK_BASE(BANK_BASE),
    .BANK_BYTES(BANK_BYTES), .IDX_W(IDX_W)
  ) u_dec (
    .waddr(bus_waddr), .hit(hit), .idx(idx)
  );

  fbc_byte_store #(
    .LANES(LANES), .BANK_BYTES(BANK_BYTES), .IDX_W(IDX_W)
  ) u_store (
    .clk(clk), .rst(rst), .wr(bus_wr), .be(bus_be), .wdata(bus_wdata),
    .hit(hit), .idx(idx), .q(bytes_q), .stat_wr(stat_wr)
  );

  fbc_irq u_irq (
    .clk(clk), .rst(rst), .frame_end(frame_end),
    .ien(bytes_q[CTRL_IDX][IEN_BIT]), .clr(stat_wr), .irq(irq)
  );

  always_comb begin
    stat_val           = IDENT_BITS;
    stat_val[PEND_BIT] = irq;
  end

  always_comb begin
    rd_next = '0;
    for (int l = 0; l < LANES; l++) begin
      if (bus_be[l] && hit[l]) begin
        if (idx[l] == IDX_W'(STAT_IDX)) rd_next[8*l +: 8] = stat_val;
        else                            rd_next[8*l +: 8] = bytes_q[idx[l]];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/fbc_ctrl_regs_tb.sv
module fbc_ctrl_regs_tb;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_VS = 2'd2, OP_IRQ = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [2:0]  wa;
    logic [3:0]  be;
    logic [31:0] d;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t TBL [NV] = '{
    '{OP_RD,  3'd4, 4'hF, 32'h0,        32'h0000_6100, 4'd1},  // R1
    '{OP_IRQ, 3'd0, 4'h0, 32'h0,        32'h0,         4'd1},  // R1
    '{OP_WR,  3'd4, 4'h1, 32'h80,       32'h0,         4'd2},
    '{OP_RD,  3'd4, 4'h1, 32'h0,        32'h0000_0080, 4'd2},  // R2
    '{OP_WR,  3'd4, 4'hF, 32'hAABBCC5A, 32'h0,         4'd8},
    '{OP_RD,  3'd4, 4'hF, 32'h0,        32'hAABB_615A, 4'd5},  // R5 data ignored
    '{OP_RD,  3'd4, 4'h5, 32'h0,        32'h00BB_005A, 4'd9},  // R9
    '{OP_WR,  3'd5, 4'hF, 32'h11223344, 32'h0,         4'd8},
    '{OP_RD,  3'd5, 4'hF, 32'h0,        32'h1122_3344, 4'd8},  // R8
    '{OP_WR,  3'd7, 4'h8, 32'hEE998877, 32'h0,         4'd9},
    '{OP_RD,  3'd7, 4'hF, 32'h0,        32'hEE00_0000, 4'd9},  // R9
    '{OP_WR,  3'd0, 4'hF, 32'hFFFFFFFF, 32'h0,         4'd10},
    '{OP_RD,  3'd0, 4'hF, 32'h0,        32'h0,         4'd10}, // R10
    '{OP_RD,  3'd4, 4'hF, 32'h0,        32'hAABB_615A, 4'd10}, // R10
    '{OP_WR,  3'd4, 4'h1, 32'h80,       32'h0,         4'd3},
    '{OP_VS,  3'd0, 4'h0, 32'h0,        32'h0,         4'd3},
    '{OP_IRQ, 3'd0, 4'h0, 32'h0,        32'h1,         4'd3},  // R3
    '{OP_RD,  3'd4, 4'h2, 32'h0,        32'h0000_E100, 4'd4},  // R4
    '{OP_RD,  3'd4, 4'h2, 32'h0,        32'h0000_E100, 4'd4},  // R4
    '{OP_IRQ, 3'd0, 4'h0, 32'h0,        32'h1,         4'd4},  // R4
    '{OP_WR,  3'd4, 4'h1, 32'h00,       32'h0,         4'd7},
    '{OP_VS,  3'd0, 4'h0, 32'h0,        32'h0,         4'd7},
    '{OP_IRQ, 3'd0, 4'h0, 32'h0,        32'h1,         4'd7},  // R7
    '{OP_WR,  3'd4, 4'h2, 32'h0000FF00, 32'h0,         4'd5},
    '{OP_IRQ, 3'd0, 4'h0, 32'h0,        32'h0,         4'd5},  // R5
    '{OP_RD,  3'd4, 4'h2, 32'h0,        32'h0000_6100, 4'd5},  // R5
    '{OP_VS,  3'd0, 4'h0, 32'h0,        32'h0,         4'd3},
    '{OP_IRQ, 3'd0, 4'h0, 32'h0,        32'h0,         4'd3},  // R3
    '{OP_RD,  3'd3, 4'hF, 32'h0,        32'h0,         4'd10}  // R10
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, frame_end = 1'b0;
  logic [2:0]  bus_waddr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int          n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  fbc_ctrl_regs u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_waddr(bus_waddr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .frame_end(frame_end), .irq(irq)
  );

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL R%0d: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic r, input logic [2:0] wa,
                     input logic [3:0] be, input logic [31:0] d, input logic vs);
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_waddr = wa; bus_be = be; bus_wdata = d; frame_end = vs;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; bus_be = '0; frame_end = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(1, bus_rdata, 32'h0);  // R1 rdata cleared
    for (int k = 0; k < NV; k++) begin
      case (TBL[k].op)
        OP_WR:  cyc(1'b1, 1'b0, TBL[k].wa, TBL[k].be, TBL[k].d, 1'b0);
        OP_RD: begin
          cyc(1'b0, 1'b1, TBL[k].wa, TBL[k].be, 32'h0, 1'b0);
          check(int'(TBL[k].req), bus_rdata, TBL[k].exp);
        end
        OP_VS:  cyc(1'b0, 1'b0, 3'd0, 4'h0, 32'h0, 1'b1);
        default: check(int'(TBL[k].req), {31'h0, irq}, TBL[k].exp);
      endcase
    end

    // R6: enable on, status write and frame end together, pending clear then set
    cyc(1'b1, 1'b0, 3'd4, 4'h1, 32'h80, 1'b0);
    cyc(1'b1, 1'b0, 3'd4, 4'h2, 32'h0, 1'b1);
    check(6, {31'h0, irq}, 32'h1);
    cyc(1'b1, 1'b0, 3'd4, 4'h2, 32'h0, 1'b1);
    check(6, {31'h0, irq}, 32'h1);
    cyc(1'b1, 1'b0, 3'd4, 4'h2, 32'hFFFF, 1'b0);
    check(5, {31'h0, irq}, 32'h0);

    // R11: read data holds across idle cycles and writes
    cyc(1'b0, 1'b1, 3'd5, 4'hF, 32'h0, 1'b0);
    check(11, bus_rdata, 32'h1122_3344);
    repeat (3) @(negedge clk);
    check(11, bus_rdata, 32'h1122_3344);
    cyc(1'b1, 1'b0, 3'd5, 4'hF, 32'h0, 1'b0);
    check(11, bus_rdata, 32'h1122_3344);
    cyc(1'b0, 1'b1, 3'd5, 4'hF, 32'h0, 1'b0);
    check(11, bus_rdata, 32'h0);

    // R1: reset in mid-run with interrupt pending and storage filled
    cyc(1'b1, 1'b0, 3'd6, 4'hF, 32'hCAFEF00D, 1'b0);
    cyc(1'b0, 1'b0, 3'd0, 4'h0, 32'h0, 1'b1);
    check(3, {31'h0, irq}, 32'h1);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    check(1, {31'h0, irq}, 32'h0);
    check(1, bus_rdata, 32'h0);
    cyc(1'b0, 1'b1, 3'd4, 4'hF, 32'h0, 1'b0);
    check(1, bus_rdata, 32'h0000_6100);
    cyc(1'b0, 1'b1, 3'd6, 4'hF, 32'h0, 1'b0);
    check(1, bus_rdata, 32'h0);
    cyc(1'b0, 1'b1, 3'd7, 4'hF, 32'h0, 1'b0);
    check(1, bus_rdata, 32'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule